// File: doc/BRIEF.md
# ADC Configuration Write-Only SPI Master

This block sends register writes to one of several converter chips over a shared serial bus. The user side places a device number, an 8-bit register address and a 16-bit data word on its inputs and raises a write strobe for one clock. The engine latches them, lowers the chip select of the chosen device, and shifts out a 32-bit frame. The frame is a 16-bit instruction word followed by the data, and every bit travels most significant first. While the engine is working its idle flag is low. Further strobes arriving in that time are dropped.

The serial clock is the system clock divided by a parameter, 4 by default (40 MHz in, 10 MHz out). Data changes when the serial clock falls and holds still while it is high. The bus has no read path. Settings that a device has staged take effect only when user logic later writes bit 0 of register 0xFF. The engine sends that write like any other.

Top module: `adc_cfg_spi_wr`

## Requirements
- R1: After reset, `idle` is 1, every `cs_n` bit is 1, and `sclk` and `mosi` are 0.
- R2: A strobe taken while `idle` is 1 makes `idle` 0 from the next cycle. It stays 0 for DIV*34 cycles in all (136 by default) and returns to 1 in the same cycle as the chip select rises.
- R3: The frame is 32 bits, sent MSB first. Bit 31 is 0 (the write flag) and bits 30:29 are 00 (the length field). Bits 28:16 carry the address, zero-extended to 13 bits. Bits 15:0 carry the data.
- R4: `sclk` has a period of DIV system clocks, with DIV/2 cycles low followed by DIV/2 cycles high. Each frame has exactly 32 rising edges. `sclk` is 0 whenever `idle` is 1.
- R5: `mosi` does not change while `sclk` is high, so each bit is stable at the rising edge.
- R6: The first rising `sclk` edge comes DIV+DIV/2 cycles after `cs_n` falls. `cs_n` rises DIV cycles after the last falling `sclk` edge.
- R7: Device select value k (k < NUM_DEV) lowers only `cs_n[k]`. At most one chip select is low at any time.
- R8: A device select of NUM_DEV or more leaves all chip selects high. The frame is still clocked out and takes the normal time.
- R9: A strobe while `idle` is 0 is ignored. The frame in flight keeps its content and no second frame follows it.
- R10: Address 0xFF gets no special treatment. A commit write with data 0x0001 goes out as frame 0x00FF0001.
- R11: A strobe in the first cycle that `idle` is back at 1 is accepted, so frames can run back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (40 MHz nominal) |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_stb | input | 1 | One-cycle request to start a write |
| dev_sel | input | 8 | Target device number |
| reg_addr | input | 8 | Register address in the target device |
| wr_data | input | 16 | Value to write |
| idle | output | 1 | High when a new write can be accepted |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| cs_n | output | NUM_DEV | Active-low chip select, one per device |

## Verification
The assertions assume that every input is synchronous to `clk` and that `rst_n` is held low through at least one rising edge before any check counts. They also assume that `dev_sel`, `reg_addr` and `wr_data` matter only on the edge where a strobe is accepted. The stimulus changes every input on the falling clock edge and gives strobes a one-cycle width. It changes the payload inputs in the middle of busy frames to show that they are latched. It also sends an out-of-range select to exercise the case where no chip select is driven.

// File: rtl/spi_wr_pkg.sv
`timescale 1ns/1ps
package spi_wr_pkg;
  // instruction word layout: write flag, two length bits, address field
  localparam int AFIELD_W = 13;
  localparam int INST_W   = 3 + AFIELD_W;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LEAD  = 2'd1,
    ST_SHIFT = 2'd2,
    ST_TRAIL = 2'd3
  } spi_st_e;
endpackage

// File: rtl/spi_wr_clkgen.sv
`timescale 1ns/1ps
module spi_wr_clkgen #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic gate,
  output logic ph_last,
  output logic sclk
);
  localparam int PH_W = $clog2(DIV);
  localparam int HALF = DIV / 2;

  logic [PH_W-1:0] ph;

  assign ph_last = (ph == PH_W'(DIV - 1));
  // low half first, high half second; falling edge coincides with period wrap
  assign sclk    = gate && (ph >= PH_W'(HALF));

  always_ff @(posedge clk) begin
    if (!rst_n)             ph <= '0;
    else if (!run || ph_last) ph <= '0;
    else                    ph <= ph + 1'b1;
  end
endmodule

// File: rtl/spi_wr_shifter.sv
`timescale 1ns/1ps
module spi_wr_shifter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         adv,
  output logic         mosi,
  output logic         last
);
  localparam int CNT_W = $clog2(W);

  logic [W-1:0]     sr;
  logic [CNT_W-1:0] cnt;

  assign mosi = sr[W-1];
  assign last = (cnt == CNT_W'(W - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sr  <= '0;
      cnt <= '0;
    end else if (load) begin
      sr  <= load_val;
      cnt <= '0;
    end else if (adv) begin
      sr  <= {sr[W-2:0], 1'b0};
      cnt <= cnt + 1'b1;
    end
  end

  // R3: a new frame is never loaded over a shift in progress
  p_adv_noload_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(load && adv));
endmodule

// File: rtl/spi_wr_csdec.sv
`timescale 1ns/1ps
module spi_wr_csdec #(
  parameter int NUM_DEV = 2,
  parameter int SEL_W   = 8
) (
  input  logic [SEL_W-1:0]   sel,
  input  logic               en,
  output logic [NUM_DEV-1:0] cs_n
);
  for (genvar i = 0; i < NUM_DEV; i++) begin : g_cs
    assign cs_n[i] = ~(en && (sel == SEL_W'(i)));
  end
endmodule

// File: rtl/adc_cfg_spi_wr.sv
`timescale 1ns/1ps
module adc_cfg_spi_wr
  import spi_wr_pkg::*;
#(
  parameter int NUM_DEV = 2,
  parameter int SEL_W   = 8,
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 16,
  parameter int DIV     = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_stb,
  input  logic [SEL_W-1:0]   dev_sel,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [DATA_W-1:0]  wr_data,
  output logic               idle,
  output logic               sclk,
  output logic               mosi,
  output logic [NUM_DEV-1:0] cs_n
);
  localparam int FRAME_W = INST_W + DATA_W;

  // frame = {write flag 0, length 00, zero-extended address, data}
  function automatic logic [FRAME_W-1:0] make_frame(
    input logic [ADDR_W-1:0] a,
    input logic [DATA_W-1:0] d
  );
    logic [AFIELD_W-1:0] af;
    af = AFIELD_W'(a);
    return {1'b0, 2'b00, af, d};
  endfunction

  spi_st_e          state, state_nxt;
  logic [SEL_W-1:0] dev_q;
  logic             start;
  logic             ph_last;
  logic             bit_last;
  logic             shift_adv;
  logic             in_shift;
  logic             busy;

  assign busy      = (state != ST_IDLE);
  assign idle      = !busy;
  assign start     = idle && wr_stb;
  assign in_shift  = (state == ST_SHIFT);
  assign shift_adv = in_shift && ph_last;

  always_comb begin
    state_nxt = state;
    unique case (state)
      ST_IDLE:  if (wr_stb)              state_nxt = ST_LEAD;
      ST_LEAD:  if (ph_last)             state_nxt = ST_SHIFT;
      ST_SHIFT: if (ph_last && bit_last) state_nxt = ST_TRAIL;
      ST_TRAIL: if (ph_last)             state_nxt = ST_IDLE;
      default:                           state_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      dev_q <= '0;
    end else begin
      state <= state_nxt;
      if (start) dev_q <= dev_sel;
    end
  end

  spi_wr_clkgen #(.DIV(DIV)) u_clk (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (busy),
    .gate    (in_shift),
    .ph_last (ph_last),
    .sclk    (sclk)
  );

  spi_wr_shifter #(.W(FRAME_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (start),
    .load_val (make_frame(reg_addr, wr_data)),
    .adv      (shift_adv),
    .mosi     (mosi),
    .last     (bit_last)
  );

  spi_wr_csdec #(.NUM_DEV(NUM_DEV), .SEL_W(SEL_W)) u_cs (
    .sel  (dev_q),
    .en   (busy),
    .cs_n (cs_n)
  );

  // R2: no chip select is low while the engine reports idle
  p_idle_cs_r2: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> (&cs_n));

  // R4: serial clock rests low between frames
  p_sclk_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> !sclk);

  // R5: data holds while the serial clock is high
  p_mosi_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && $past(sclk)) |-> $stable(mosi));

  // R7: never more than one device selected
  p_cs_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n));

  // R8: out-of-range select drives no chip select
  p_bad_sel_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_q >= SEL_W'(NUM_DEV)) |-> (&cs_n));

  // R9: a strobe during a frame leaves the latched target untouched
  p_busy_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_stb) |=> $stable(dev_q));
endmodule

// File: tb/adc_cfg_spi_wr_tb.sv
`timescale 1ns/1ps
module adc_cfg_spi_wr_tb;
  localparam int NUM_DEV = 2;
  localparam int DIV     = 4;
  localparam int NBITS   = 32;
  localparam int BUSY_CY = DIV * (NBITS + 2);
  localparam int LEAD_CY = DIV + DIV / 2;
  localparam int TRAIL_CY = DIV;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_stb = 1'b0;
  logic [7:0]  dev_sel = '0;
  logic [7:0]  reg_addr = '0;
  logic [15:0] wr_data = '0;
  logic idle, sclk, mosi;
  logic [NUM_DEV-1:0] cs_n;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  adc_cfg_spi_wr #(.NUM_DEV(NUM_DEV), .DIV(DIV)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .dev_sel(dev_sel),
    .reg_addr(reg_addr), .wr_data(wr_data), .idle(idle), .sclk(sclk),
    .mosi(mosi), .cs_n(cs_n)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // bench's own view of the frame: 8 zero bits above an 8-bit address, then data
  function automatic logic [31:0] expect_frame(input logic [7:0] a, input logic [15:0] d);
    logic [31:0] f;
    f = '0;
    f[23:16] = a;
    f[15:0]  = d;
    return f;
  endfunction

  // runs one write and checks it; optionally injects a second strobe at cycle inj_k
  task automatic run_frame(input logic [7:0] sel, input logic [7:0] a, input logic [15:0] d,
                           input int inj_k, input string tag);
    logic [31:0] got;
    int k, rises, unstable, cs_fall_k, first_rise_k, last_fall_k, cs_rise_k, busy_cnt;
    logic [NUM_DEV-1:0] cs_seen;
    logic ps, pm;
    logic [NUM_DEV-1:0] exp_mask;
    got = '0; rises = 0; unstable = 0; cs_fall_k = -1; first_rise_k = -1;
    last_fall_k = -1; cs_rise_k = -1; busy_cnt = 0; cs_seen = '0;
    dev_sel = sel; reg_addr = a; wr_data = d; wr_stb = 1'b1;
    ps = sclk; pm = mosi;
    @(negedge clk);
    wr_stb = 1'b0;
    dev_sel = ~sel; reg_addr = ~a; wr_data = ~d;
    k = 1;
    while (k < 1000) begin
      if (!idle) busy_cnt++;
      cs_seen |= ~cs_n;
      if (cs_fall_k < 0 && !(&cs_n)) cs_fall_k = k;
      if (sclk && !ps) begin
        rises++;
        got = {got[30:0], mosi};
        if (first_rise_k < 0) first_rise_k = k;
      end
      if (!sclk && ps) last_fall_k = k;
      if (sclk && ps && mosi != pm) unstable++;
      if (idle) begin
        cs_rise_k = k;
        break;
      end
      ps = sclk; pm = mosi;
      if (k == inj_k) begin
        dev_sel = 8'd0; reg_addr = 8'h5A; wr_data = 16'hDEAD; wr_stb = 1'b1;
      end else begin
        wr_stb = 1'b0;
      end
      @(negedge clk);
      k++;
    end
    wr_stb = 1'b0;
    exp_mask = (sel < NUM_DEV) ? NUM_DEV'(1 << sel) : '0;
    chk(k < 1000, {tag, " R2 frame ends"}, k, BUSY_CY + 1);
    chk(got == expect_frame(a, d), {tag, " R3 frame bits"}, got, expect_frame(a, d));
    chk(rises == NBITS, {tag, " R4 rising edges"}, rises, NBITS);
    chk(busy_cnt == BUSY_CY, {tag, " R2 idle low cycles"}, busy_cnt, BUSY_CY);
    chk(unstable == 0, {tag, " R5 mosi moved while sclk high"}, unstable, 0);
    chk(cs_seen == exp_mask, {tag, " R7 R8 chip select mask"}, cs_seen, exp_mask);
    if (sel < NUM_DEV) begin
      chk(first_rise_k - cs_fall_k == LEAD_CY, {tag, " R6 lead"}, first_rise_k - cs_fall_k, LEAD_CY);
      chk(cs_rise_k - last_fall_k == TRAIL_CY, {tag, " R6 trail"}, cs_rise_k - last_fall_k, TRAIL_CY);
    end
  endtask

  task automatic t_reset;
    chk(idle == 1'b1, "R1 idle after reset", idle, 1);
    chk(&cs_n, "R1 cs high after reset", cs_n, {NUM_DEV{1'b1}});
    chk(sclk == 1'b0, "R1 sclk low after reset", sclk, 0);
    chk(mosi == 1'b0, "R1 mosi low after reset", mosi, 0);
  endtask

  task automatic t_basic;
    run_frame(8'd0, 8'h14, 16'hA5C3, -1, "dev0");
    run_frame(8'd1, 8'h08, 16'h0F0F, -1, "dev1");
  endtask

  task automatic t_bad_sel;
    run_frame(8'd5, 8'h22, 16'h1234, -1, "R8 badsel");
  endtask

  task automatic t_busy_ignore;
    int extra;
    run_frame(8'd1, 8'h3C, 16'h8001, 40, "R9 busy");
    extra = 0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (!idle || !(&cs_n)) extra++;
    end
    chk(extra == 0, "R9 no follow-up frame", extra, 0);
  endtask

  task automatic t_commit;
    chk(expect_frame(8'hFF, 16'h0001) == 32'h00FF0001, "R10 commit encoding", expect_frame(8'hFF, 16'h0001), 32'h00FF0001);
    run_frame(8'd0, 8'hFF, 16'h0001, -1, "R10 commit");
  endtask

  task automatic t_back_to_back;
    run_frame(8'd0, 8'hC1, 16'hFFFF, -1, "R11 first");
    run_frame(8'd1, 8'h7E, 16'h0000, -1, "R11 second");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_bad_sel();
    t_busy_ignore();
    t_commit();
    t_back_to_back();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule